// File: doc/BRIEF.md
# Clock Frequency Source Selector

This control block decides which frequency setting a clock synthesizer uses. When the power-good input first goes low after reset, it captures five strap inputs and keeps them. From then on it produces a gear index and an N/M divider pair. It takes them from one of three places: the captured straps, a five-bit software select field, or a programmed N/M pair.

A watchdog can command recovery. The block then loads a recovery setting and freezes its outputs until software releases it. Each applied change produces a one-cycle strobe. It can also produce an active-low reset request of fixed length. All outputs are registered control words. No clock is generated here.

Top module: `freq_src_sel`

## Requirements
- R1: On the first clock edge after reset where `pwr_good_ni` is low, `strap_i` is captured into `strap_o` and `strap_valid_o` rises. Later strap or power-good activity has no effect on `strap_o`.
- R2: Outside recovery, with `prog_en_i` low, `gear_o` equals `sw_sel_i` when `ovr_i` is 1 and the captured straps when `ovr_i` is 0. In this case `n_o`, `m_o` and `prog_o` are 0.
- R3: Outside recovery, with `prog_en_i` high and a valid pair, `n_o`/`m_o` take `prog_n_i`/`prog_m_i` and `prog_o` is 1. `gear_o` is chosen by `ovr_i` as in R2.
- R4: A pair is valid only when (N+3)/(M+3) > 1, that is N > M. An invalid programmed pair leaves every output unchanged.
- R5: A `prog_wr_i` pulse in programmable mode with a valid pair produces a change strobe even when the values do not differ.
- R6: An applied setting appears on the outputs one clock edge after the inputs that select it. `chg_o` is high for exactly that cycle and only when the setting differs from the previous one or R5 applies.
- R7: A `recover_i` pulse outside recovery sets `locked_o` and applies a recovery setting. Its gear always comes from the captured straps. With `rcv_sel_i` = 0 the setting uses no N/M. With `rcv_sel_i` = 1 it uses `rcv_n_i`/`rcv_m_i`, or no N/M if that pair is invalid.
- R8: While `locked_o` is 1, all setting outputs hold and software writes have no effect. A `unlock_i` pulse clears `locked_o`. The normal selection is applied on the following edge.
- R9: If `rst_on_chg_i` is 1 at the edge that applies a change, `rst_req_no` goes low for exactly RST_LEN cycles. A new change restarts the count.
- R10: Before the straps are captured, all setting outputs stay 0 and no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_ni | input | 1 | Power-good, active low; triggers strap capture |
| strap_i | input | 5 | Frequency strap inputs |
| ovr_i | input | 1 | 1: software select field sets gear |
| sw_sel_i | input | 5 | Software gear select field |
| prog_en_i | input | 1 | Programmable N/M mode enable |
| prog_n_i | input | 8 | Programmed N value |
| prog_m_i | input | 7 | Programmed M value |
| prog_wr_i | input | 1 | Pulse: N or M register written |
| rcv_sel_i | input | 1 | Recovery source: 0 straps, 1 recovery pair |
| rcv_n_i | input | 8 | Recovery N value |
| rcv_m_i | input | 7 | Recovery M value |
| recover_i | input | 1 | Pulse from watchdog: enter recovery |
| unlock_i | input | 1 | Pulse: leave recovery |
| rst_on_chg_i | input | 1 | Request reset on each applied change |
| strap_o | output | 5 | Captured straps |
| strap_valid_o | output | 1 | Straps captured |
| gear_o | output | 5 | Applied gear index |
| n_o | output | 8 | Applied N |
| m_o | output | 7 | Applied M |
| prog_o | output | 1 | Applied setting uses N/M |
| chg_o | output | 1 | One-cycle change strobe |
| locked_o | output | 1 | Recovery lock active |
| rst_req_no | output | 1 | Reset request, active low |

## Verification
The stimulus first moves the straps before and after capture, so a design that keeps sampling can be told apart from one that holds its value. The select tests flip the override bit with programmable mode off and then on. This shows whether the gear and the N/M pair follow separate selections. Pairs with N above, equal to and below M show whether the validity test is strict. A rewrite of an unchanged pair shows whether the strobe follows writes or only value changes. Recovery is entered once with each value of the recovery-select bit, with software writes in between. This shows whether the freeze holds and whether the release returns to the live software setting.

// File: rtl/freq_sel_pkg.sv
package freq_sel_pkg;
  parameter int GEAR_W = 5;
  parameter int N_W    = 8;
  parameter int M_W    = 7;

  typedef struct packed {
    logic              prog;
    logic [GEAR_W-1:0] gear;
    logic [N_W-1:0]    n;
    logic [M_W-1:0]    m;
  } freq_cfg_t;

  // (N+3)/(M+3) > 1  <=>  N > M
  function automatic logic pair_ok(input logic [N_W-1:0] n, input logic [M_W-1:0] m);
    return n > N_W'(m);
  endfunction
endpackage

// File: rtl/fss_strap_latch.sv
module fss_strap_latch
  import freq_sel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_ni,
  input  logic [GEAR_W-1:0] strap_i,
  output logic [GEAR_W-1:0] strap_o,
  output logic              cap_o
);
  logic [GEAR_W-1:0] strap_q;
  logic              cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q <= '0;
      cap_q   <= 1'b0;
    end else if (!cap_q && !pwr_good_ni) begin
      strap_q <= strap_i;
      cap_q   <= 1'b1;
    end
  end

  assign strap_o = strap_q;
  assign cap_o   = cap_q;

  AST_STRAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cap_q) |-> $stable(strap_q)); // R1
endmodule

// File: rtl/fss_src_mux.sv
module fss_src_mux
  import freq_sel_pkg::*;
(
  input  logic [GEAR_W-1:0] strap_i,
  input  logic              ovr_i,
  input  logic [GEAR_W-1:0] sw_sel_i,
  input  logic              prog_en_i,
  input  logic [N_W-1:0]    prog_n_i,
  input  logic [M_W-1:0]    prog_m_i,
  input  logic              prog_wr_i,
  input  logic              rcv_sel_i,
  input  logic [N_W-1:0]    rcv_n_i,
  input  logic [M_W-1:0]    rcv_m_i,
  output freq_cfg_t         norm_cfg_o,
  output logic              norm_ok_o,
  output logic              force_o,
  output freq_cfg_t         rcv_cfg_o
);
  logic [GEAR_W-1:0] gear_src;

  assign gear_src = ovr_i ? sw_sel_i : strap_i;

  always_comb begin
    norm_cfg_o = '{prog: 1'b0, gear: gear_src, n: '0, m: '0};
    norm_ok_o  = 1'b1;
    if (prog_en_i) begin
      norm_cfg_o = '{prog: 1'b1, gear: gear_src, n: prog_n_i, m: prog_m_i};
      norm_ok_o  = pair_ok(prog_n_i, prog_m_i);
    end
  end

  assign force_o = prog_en_i && prog_wr_i && norm_ok_o;

  always_comb begin
    rcv_cfg_o = '{prog: 1'b0, gear: strap_i, n: '0, m: '0};
    if (rcv_sel_i && pair_ok(rcv_n_i, rcv_m_i))
      rcv_cfg_o = '{prog: 1'b1, gear: strap_i, n: rcv_n_i, m: rcv_m_i};
  end
endmodule

// File: rtl/fss_apply_ctl.sv
module fss_apply_ctl
  import freq_sel_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cap_i,
  input  freq_cfg_t norm_cfg_i,
  input  logic      norm_ok_i,
  input  logic      force_i,
  input  freq_cfg_t rcv_cfg_i,
  input  logic      recover_i,
  input  logic      unlock_i,
  output freq_cfg_t cfg_o,
  output logic      chg_d_o,
  output logic      chg_o,
  output logic      locked_o
);
  freq_cfg_t cfg_q, cfg_d;
  logic      locked_q, locked_d, chg_q, chg_d;

  always_comb begin
    cfg_d    = cfg_q;
    locked_d = locked_q;
    chg_d    = 1'b0;
    if (cap_i) begin
      if (locked_q) begin
        if (unlock_i) locked_d = 1'b0;
      end else if (recover_i) begin
        locked_d = 1'b1;
        cfg_d    = rcv_cfg_i;
        chg_d    = rcv_cfg_i != cfg_q;
      end else if (norm_ok_i) begin
        cfg_d = norm_cfg_i;
        chg_d = (norm_cfg_i != cfg_q) || force_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      locked_q <= 1'b0;
      chg_q    <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      locked_q <= locked_d;
      chg_q    <= chg_d;
    end
  end

  assign cfg_o    = cfg_q;
  assign chg_o    = chg_q;
  assign chg_d_o  = chg_d;
  assign locked_o = locked_q;

  AST_LOCK_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(locked_q) |-> $stable(cfg_q)); // R8
  AST_PAIR_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.prog |-> (cfg_q.n > N_W'(cfg_q.m))); // R4
  AST_CHG_ON_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q != $past(cfg_q)) |-> chg_q); // R6
  AST_NO_CHG_PRECAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> (!chg_q && cfg_q == '0)); // R10
endmodule

// File: rtl/fss_rst_pulse.sv
module fss_rst_pulse #(
  parameter int RST_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic en_i,
  output logic rst_req_no
);
  localparam int CNT_W = $clog2(RST_LEN + 1);
  localparam logic [CNT_W-1:0] LEN = CNT_W'(RST_LEN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (trig_i && en_i)  cnt_q <= LEN;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign rst_req_no = (cnt_q == '0);

  AST_RST_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && en_i) |=> !rst_req_no); // R9
  AST_RST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_req_no) && !$past(trig_i && en_i)) |-> rst_req_no); // R9
endmodule

// File: rtl/freq_src_sel.sv
module freq_src_sel
  import freq_sel_pkg::*;
#(
  parameter int RST_LEN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_ni,
  input  logic [GEAR_W-1:0] strap_i,
  input  logic              ovr_i,
  input  logic [GEAR_W-1:0] sw_sel_i,
  input  logic              prog_en_i,
  input  logic [N_W-1:0]    prog_n_i,
  input  logic [M_W-1:0]    prog_m_i,
  input  logic              prog_wr_i,
  input  logic              rcv_sel_i,
  input  logic [N_W-1:0]    rcv_n_i,
  input  logic [M_W-1:0]    rcv_m_i,
  input  logic              recover_i,
  input  logic              unlock_i,
  input  logic              rst_on_chg_i,
  output logic [GEAR_W-1:0] strap_o,
  output logic              strap_valid_o,
  output logic [GEAR_W-1:0] gear_o,
  output logic [N_W-1:0]    n_o,
  output logic [M_W-1:0]    m_o,
  output logic              prog_o,
  output logic              chg_o,
  output logic              locked_o,
  output logic              rst_req_no
);
  logic [GEAR_W-1:0] strap_q;
  logic              cap, norm_ok, force_ld, chg_d;
  freq_cfg_t         norm_cfg, rcv_cfg, cfg;

  fss_strap_latch i_strap (
    .clk_i, .rst_ni, .pwr_good_ni, .strap_i,
    .strap_o(strap_q), .cap_o(cap)
  );

  fss_src_mux i_mux (
    .strap_i(strap_q), .ovr_i, .sw_sel_i, .prog_en_i, .prog_n_i, .prog_m_i,
    .prog_wr_i, .rcv_sel_i, .rcv_n_i, .rcv_m_i,
    .norm_cfg_o(norm_cfg), .norm_ok_o(norm_ok), .force_o(force_ld), .rcv_cfg_o(rcv_cfg)
  );

  fss_apply_ctl i_apply (
    .clk_i, .rst_ni, .cap_i(cap), .norm_cfg_i(norm_cfg), .norm_ok_i(norm_ok),
    .force_i(force_ld), .rcv_cfg_i(rcv_cfg), .recover_i, .unlock_i,
    .cfg_o(cfg), .chg_d_o(chg_d), .chg_o, .locked_o
  );

  fss_rst_pulse #(.RST_LEN(RST_LEN)) i_rst (
    .clk_i, .rst_ni, .trig_i(chg_d), .en_i(rst_on_chg_i), .rst_req_no
  );

  assign strap_o       = strap_q;
  assign strap_valid_o = cap;
  assign gear_o        = cfg.gear;
  assign n_o           = cfg.n;
  assign m_o           = cfg.m;
  assign prog_o        = cfg.prog;
endmodule

// File: tb/test_freq_src_sel.sv
module test_freq_src_sel;
  localparam int L = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pg_n = 1'b1, ovr = 0, prog_en = 0, prog_wr = 0, rcv_sel = 0;
  logic recover = 0, unlock = 0, rst_en = 0;
  logic [4:0] strap = 5'h1F, sw_sel = 0;
  logic [7:0] pn = 0, rn = 0;
  logic [6:0] pm = 0, rm = 0;
  logic [4:0] strap_o, gear_o;
  logic [7:0] n_o;
  logic [6:0] m_o;
  logic strap_valid_o, prog_o, chg_o, locked_o, rst_req_no;

  int compared = 0, mismatched = 0;

  always #2.5 clk = ~clk;

  freq_src_sel #(.RST_LEN(L)) i_freq_src_sel (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_ni(pg_n), .strap_i(strap),
    .ovr_i(ovr), .sw_sel_i(sw_sel), .prog_en_i(prog_en), .prog_n_i(pn), .prog_m_i(pm),
    .prog_wr_i(prog_wr), .rcv_sel_i(rcv_sel), .rcv_n_i(rn), .rcv_m_i(rm),
    .recover_i(recover), .unlock_i(unlock), .rst_on_chg_i(rst_en),
    .strap_o, .strap_valid_o, .gear_o, .n_o, .m_o, .prog_o, .chg_o, .locked_o, .rst_req_no
  );

  // behavioural reference
  bit md_cap, md_lock, md_prog, md_chg;
  int md_strap, md_gear, md_n, md_m, md_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      md_cap = 0; md_lock = 0; md_prog = 0; md_chg = 0;
      md_strap = 0; md_gear = 0; md_n = 0; md_m = 0; md_cnt = 0;
    end else begin
      bit c, tp; int tg, tn, tm;
      c = 0;
      if (!md_cap) begin
        if (!pg_n) begin md_cap = 1; md_strap = strap; end
      end else if (md_lock) begin
        if (unlock) md_lock = 0;
      end else if (recover) begin
        md_lock = 1; tg = md_strap;
        if (rcv_sel && rn > rm) begin tp = 1; tn = rn; tm = rm; end
        else begin tp = 0; tn = 0; tm = 0; end
        c = (tp != md_prog) || (tg != md_gear) || (tn != md_n) || (tm != md_m);
        md_prog = tp; md_gear = tg; md_n = tn; md_m = tm;
      end else begin
        tg = ovr ? sw_sel : md_strap;
        if (!prog_en || pn > pm) begin
          tp = prog_en; tn = prog_en ? pn : 0; tm = prog_en ? pm : 0;
          c = (tp != md_prog) || (tg != md_gear) || (tn != md_n) || (tm != md_m)
              || (prog_en && prog_wr);
          md_prog = tp; md_gear = tg; md_n = tn; md_m = tm;
        end
      end
      if (c && rst_en) md_cnt = L;
      else if (md_cnt > 0) md_cnt--;
      md_chg = c;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(strap_o == md_strap[4:0] && strap_valid_o == md_cap, "R1 strap", strap_o, md_strap);
    chk(gear_o == md_gear[4:0], "R2 gear", gear_o, md_gear);
    chk(n_o == md_n[7:0] && m_o == md_m[6:0] && prog_o == md_prog, "R3 n/m",
        {prog_o, n_o, 1'b0, m_o}, {md_prog, md_n[7:0], 1'b0, md_m[6:0]});
    chk(chg_o == md_chg, "R6 chg", chg_o, md_chg);
    chk(locked_o == md_lock, "R8 locked", locked_o, md_lock);
    chk(rst_req_no == (md_cnt == 0), "R9 rst_req", rst_req_no, md_cnt == 0);
  end

  task automatic cyc(input int k = 1);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic pulse(ref logic s);
    s = 1; cyc(); s = 0;
  endtask

  initial begin
    #(5 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    cyc(2); rst_n = 1; cyc();
    chk(gear_o == 0 && n_o == 0 && !chg_o && rst_req_no, "R10 reset state", gear_o, 0);
    strap = 5'h07; cyc(3); strap = 5'h12; cyc(2);
    chk(!strap_valid_o && gear_o == 0 && !chg_o, "R10 pre-capture", gear_o, 0);
    strap = 5'h0B; pg_n = 0; cyc();
    chk(strap_o == 5'h0B && strap_valid_o, "R1 capture", strap_o, 5'h0B);
    strap = 5'h1F; pg_n = 1; cyc();
    chk(gear_o == 5'h0B && chg_o, "R2 strap gear", gear_o, 5'h0B);
    pg_n = 0; cyc(3);
    chk(strap_o == 5'h0B && !chg_o, "R1 held", strap_o, 5'h0B);
    sw_sel = 5'h03; cyc(2);
    chk(gear_o == 5'h0B, "R2 sel ignored without override", gear_o, 5'h0B);
    ovr = 1; cyc();
    chk(gear_o == 5'h03 && chg_o && !prog_o, "R2 override", gear_o, 5'h03);
    cyc();
    chk(!chg_o, "R6 strobe one cycle", chg_o, 0);
    pn = 100; pm = 45; prog_en = 1; cyc();
    chk(n_o == 100 && m_o == 45 && prog_o && gear_o == 5'h03, "R3 prog pair", n_o, 100);
    ovr = 0; cyc();
    chk(gear_o == 5'h0B && n_o == 100, "R3 gear from straps", gear_o, 5'h0B);
    cyc(2); pulse(prog_wr);
    chk(chg_o, "R5 rewrite strobe", chg_o, 1);
    pn = 45; cyc(2);
    chk(n_o == 100 && !chg_o, "R4 equal pair rejected", n_o, 100);
    pn = 30; ovr = 1; cyc(2);
    chk(n_o == 100 && gear_o == 5'h0B, "R4 low pair rejected", n_o, 100);
    pn = 46; cyc();
    chk(n_o == 46 && gear_o == 5'h03, "R4 N=M+1 accepted", n_o, 46);
    rst_en = 1; pn = 120; cyc();
    begin
      int low = 0;
      for (int i = 0; i < L + 4; i++) begin if (!rst_req_no) low++; cyc(); end
      chk(low == L, "R9 pulse length", low, L);
    end
    rn = 200; rm = 10; rcv_sel = 1; pulse(recover);
    chk(locked_o && n_o == 200 && m_o == 10 && gear_o == 5'h0B, "R7 recovery pair", n_o, 200);
    pn = 150; sw_sel = 5'h05; pulse(prog_wr); rn = 220; cyc(3);
    chk(n_o == 200 && gear_o == 5'h0B && !chg_o, "R8 locked frozen", n_o, 200);
    pulse(unlock);
    chk(!locked_o && n_o == 200, "R8 release edge", n_o, 200);
    cyc();
    chk(n_o == 150 && gear_o == 5'h05, "R8 normal after release", n_o, 150);
    rcv_sel = 0; pulse(recover);
    chk(locked_o && !prog_o && gear_o == 5'h0B && n_o == 0, "R7 recovery straps", gear_o, 5'h0B);
    cyc(2); pulse(unlock); cyc();
    rcv_sel = 1; rn = 5; rm = 9; pulse(recover);
    chk(locked_o && !prog_o && gear_o == 5'h0B, "R7 invalid recovery pair", prog_o, 0);
    cyc(2); pulse(unlock); prog_en = 0; cyc(3);
    chk(!prog_o && gear_o == 5'h05, "R2 prog off again", gear_o, 5'h05);
    cyc(12);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule